// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block guards a system against hung software by watching a free-running 64-bit system counter that arrives on an input port. It compares that counter against an absolute 64-bit deadline. The deadline is rebuilt from a programmable 32-bit interval each time software services the block. If the deadline passes once, the block raises a first-stage interrupt and arms a second deadline one interval later. If that second deadline also passes with no service, a second-stage signal goes high and stays high. That signal is meant for a reset generator or an escalation path.

Software reaches the block through two independent 4 KiB windows, each a plain 32-bit register bus with byte offsets. The service window holds only the kick register. Any write to its offset 0x000 counts as service, so that window carries no write data. The control window holds the status/enable register, the interval and the two halves of the deadline. Both windows return a fixed identification word at offset 0xFCC. Reads are combinational, and every write takes effect at the clock edge on which it is presented.

Top module: `wdog2_stage`

## Requirements
- R1: After reset, enable, both stage flags, the interval and the deadline are all zero, and both stage outputs are low.
- R2: A write to service-window offset 0x000 loads deadline = counter + interval and clears both stage flags. It does this whatever the enable state.
- R3: A write to control offset 0x008 stores the 32-bit interval, loads deadline = counter + new interval and clears both stage flags.
- R4: A write to control offset 0x000 sets enable from data bit 0 and clears both stage flags. When bit 0 is 1, it also loads deadline = counter + interval. Writing 0 disables the block.
- R5: Control offset 0x000 reads enable in bit 0, the first-stage flag in bit 1 and the second-stage flag in bit 2, with zero above. Data bits 1 and 2 of a write there are ignored.
- R6: While enabled with the first-stage flag clear, a counter greater than or equal to the deadline at a clock edge sets the first-stage flag on that edge. On the same edge it reloads deadline = counter + interval.
- R7: While enabled with the first-stage flag set, a counter at or past the deadline sets the second-stage flag. The deadline is left unchanged and both flags hold until service or a control-register write.
- R8: While disabled, no stage flag is ever set, however far the counter runs.
- R9: Control offsets 0x010 and 0x014 read and write the low and high halves of the deadline directly.
- R10: Offset 0xFCC in either window reads the identification word given by a parameter (default 0x0200143B).
- R11: Unmapped offsets, and the service register itself, read as zero. Writes to unmapped control offsets change nothing.
- R12: The stage outputs are high exactly when the corresponding flag reads back as set.
- R13: A software write to service, interval or status takes priority over a timeout that falls on the same edge. In that case no stage flag is set on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Free-running system counter |
| svc_we | input | 1 | Service window write strobe |
| svc_addr | input | 12 | Service window byte offset |
| svc_rdata | output | 32 | Service window read data (combinational) |
| ctl_we | input | 1 | Control window write strobe |
| ctl_addr | input | 12 | Control window byte offset |
| ctl_wdata | input | 32 | Control window write data |
| ctl_rdata | output | 32 | Control window read data (combinational) |
| stage1_irq | output | 1 | First-stage timeout, level |
| stage2_irq | output | 1 | Second-stage timeout, level |

## Verification
Every register write and every timeout lands on the clock edge where the stimulus is presented. Read data is combinational, so each result is due one time step after that edge. The bench drives strobes, addresses and the counter on the falling edge and samples just after the following rising edge. Deadline boundaries are checked at exactly one tick short and one tick equal, so a result that arrives a cycle early or late shows up at once. The same-edge race between a service write and an expiry is driven in a single cycle so that priority can be observed.

// File: rtl/wdog2_stage.sv
module wdog2_stage #(
  parameter int          AW      = 12,
  parameter logic [31:0] ID_WORD = 32'h0200_143B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   sys_count,
  input  logic          svc_we,
  input  logic [AW-1:0] svc_addr,
  output logic [31:0]   svc_rdata,
  input  logic          ctl_we,
  input  logic [AW-1:0] ctl_addr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  output logic          stage1_irq,
  output logic          stage2_irq
);
  localparam logic [AW-1:0] A_KICK = AW'('h000);
  localparam logic [AW-1:0] A_STAT = AW'('h000);
  localparam logic [AW-1:0] A_IVAL = AW'('h008);
  localparam logic [AW-1:0] A_DLO  = AW'('h010);
  localparam logic [AW-1:0] A_DHI  = AW'('h014);
  localparam logic [AW-1:0] A_ID   = AW'('hFCC);

  logic        en_q, ws0_q, ws1_q;
  logic [31:0] ival_q;
  logic [63:0] dl_q;

  wire kick_we = svc_we && svc_addr == A_KICK;
  wire stat_we = ctl_we && ctl_addr == A_STAT;
  wire ival_we = ctl_we && ctl_addr == A_IVAL;
  wire dlo_we  = ctl_we && ctl_addr == A_DLO;
  wire dhi_we  = ctl_we && ctl_addr == A_DHI;
  wire clr_ws  = kick_we || stat_we || ival_we;
  wire expired = en_q && (sys_count >= dl_q);
  wire [63:0] reload = sys_count + {32'd0, ival_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ws0_q  <= 1'b0;
      ws1_q  <= 1'b0;
      ival_q <= '0;
      dl_q   <= '0;
    end else begin
      if (stat_we) en_q <= ctl_wdata[0];
      if (ival_we) ival_q <= ctl_wdata;

      if (ival_we)                            dl_q <= sys_count + {32'd0, ctl_wdata};
      else if (kick_we || (stat_we && ctl_wdata[0])) dl_q <= reload;
      else if (dlo_we)                        dl_q[31:0] <= ctl_wdata;
      else if (dhi_we)                        dl_q[63:32] <= ctl_wdata;
      else if (expired && !ws0_q)             dl_q <= reload;

      if (clr_ws) begin
        ws0_q <= 1'b0;
        ws1_q <= 1'b0;
      end else if (expired && !dlo_we && !dhi_we) begin
        if (!ws0_q) ws0_q <= 1'b1;
        else        ws1_q <= 1'b1;
      end
    end
  end

  assign stage1_irq = ws0_q;
  assign stage2_irq = ws1_q;

  always_comb begin
    case (ctl_addr)
      A_STAT:  ctl_rdata = {29'd0, ws1_q, ws0_q, en_q};
      A_IVAL:  ctl_rdata = ival_q;
      A_DLO:   ctl_rdata = dl_q[31:0];
      A_DHI:   ctl_rdata = dl_q[63:32];
      A_ID:    ctl_rdata = ID_WORD;
      default: ctl_rdata = '0;
    endcase
  end

  assign svc_rdata = (svc_addr == A_ID) ? ID_WORD : 32'd0;

  // R7
  stage2_needs_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_irq |-> stage1_irq);

  // R8
  no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage1_irq) |-> $past(en_q));

  // R2
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_we && !ctl_we) |=> (!stage1_irq && !stage2_irq &&
      dl_q == $past(sys_count) + {32'd0, $past(ival_q)}));

  // R6
  stage1_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage1_irq) |-> dl_q == $past(sys_count) + {32'd0, $past(ival_q)});

  // R7
  stage2_hold_dl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage2_irq) |-> $stable(dl_q));
endmodule

// File: tb/wdog2_stage_test.sv
module wdog2_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h0200_143B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        svc_we = 1'b0;
  logic [11:0] svc_addr = '0;
  logic [31:0] svc_rdata;
  logic        ctl_we = 1'b0;
  logic [11:0] ctl_addr = '0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        stage1_irq, stage2_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog2_stage uut (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
    .svc_we(svc_we), .svc_addr(svc_addr), .svc_rdata(svc_rdata),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .stage1_irq(stage1_irq), .stage2_irq(stage2_irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic ctl_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    svc_we = 1'b1; svc_addr = 12'h000;
    tick();
    svc_we = 1'b0;
  endtask

  task automatic set_count(input logic [63:0] c);
    @(negedge clk);
    sys_count = c;
  endtask

  function automatic logic [31:0] ctl_rd(input logic [11:0] a);
    ctl_addr = a;
    return ctl_rdata;
  endfunction

  task automatic rd_ctl(input string tag, input logic [11:0] a, input logic [31:0] exp);
    ctl_addr = a; #1;
    check(tag, ctl_rdata, exp);
  endtask

  task automatic rd_dl(input string tag, input logic [63:0] exp);
    logic [63:0] v;
    ctl_addr = 12'h010; #1; v[31:0] = ctl_rdata;
    ctl_addr = 12'h014; #1; v[63:32] = ctl_rdata;
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    rd_ctl("R1 status", 12'h000, 0);
    rd_ctl("R1 interval", 12'h008, 0);
    rd_dl("R1 deadline", 0);
    check("R1 stage1", stage1_irq, 0);
    check("R1 stage2", stage2_irq, 0);
  endtask

  task automatic t_id_unmapped();
    svc_addr = 12'hFCC; #1;
    check("R10 svc id", svc_rdata, ID);
    rd_ctl("R10 ctl id", 12'hFCC, ID);
    svc_addr = 12'h000; #1;
    check("R11 kick reads zero", svc_rdata, 0);
    rd_ctl("R11 unmapped read", 12'h004, 0);
    ctl_wr(12'h004, 32'hFFFF_FFFF);
    ctl_wr(12'h00C, 32'hFFFF_FFFF);
    rd_ctl("R11 status untouched", 12'h000, 0);
    rd_ctl("R11 interval untouched", 12'h008, 0);
    rd_dl("R11 deadline untouched", 0);
  endtask

  task automatic t_deadline_rw();
    ctl_wr(12'h010, 32'h1234_5678);
    ctl_wr(12'h014, 32'h9ABC_DEF0);
    rd_dl("R9 deadline rw", 64'h9ABC_DEF0_1234_5678);
  endtask

  task automatic t_interval();
    set_count(1000);
    ctl_wr(12'h008, 50);
    rd_ctl("R3 interval", 12'h008, 50);
    rd_dl("R3 deadline", 1050);
  endtask

  task automatic t_enable();
    set_count(2000);
    ctl_wr(12'h000, 1);
    rd_ctl("R4 enabled", 12'h000, 1);
    rd_dl("R4 deadline", 2050);
    ctl_wr(12'h000, 7);
    rd_ctl("R5 flag bits ignored", 12'h000, 1);
  endtask

  task automatic t_escalate();
    set_count(2049); tick();
    check("R6 one short", stage1_irq, 0);
    set_count(2050); tick();
    check("R6 stage1 set", stage1_irq, 1);
    check("R12 stage2 low", stage2_irq, 0);
    rd_ctl("R5 status ws0", 12'h000, 3);
    rd_dl("R6 rearm", 2100);
    set_count(2099); tick();
    check("R7 one short", stage2_irq, 0);
    set_count(2100); tick();
    check("R7 stage2 set", stage2_irq, 1);
    rd_dl("R7 deadline held", 2100);
    set_count(5000); tick(); tick(); tick();
    check("R7 stage2 holds", stage2_irq, 1);
    check("R12 stage1 holds", stage1_irq, 1);
    rd_ctl("R5 status both", 12'h000, 7);
    rd_dl("R7 deadline still", 2100);
  endtask

  task automatic t_kick();
    kick();
    check("R2 stage1 cleared", stage1_irq, 0);
    check("R2 stage2 cleared", stage2_irq, 0);
    rd_dl("R2 deadline", 5050);
    rd_ctl("R2 still enabled", 12'h000, 1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    sys_count = 6000; svc_we = 1'b1; svc_addr = 12'h000;
    tick();
    svc_we = 1'b0;
    check("R13 no flag", stage1_irq, 0);
    rd_dl("R13 deadline", 6050);
  endtask

  task automatic t_disable();
    set_count(6050); tick();
    check("R6 set before off", stage1_irq, 1);
    ctl_wr(12'h000, 0);
    rd_ctl("R4 disabled", 12'h000, 0);
    check("R4 flag cleared", stage1_irq, 0);
    set_count(64'd9000); tick(); tick(); tick();
    check("R8 no stage1", stage1_irq, 0);
    check("R8 no stage2", stage2_irq, 0);
    rd_ctl("R8 status", 12'h000, 0);
    kick();
    rd_dl("R2 kick while off", 9050);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_id_unmapped();
    t_deadline_rw();
    t_interval();
    t_enable();
    t_escalate();
    t_kick();
    t_priority();
    t_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule